// File: doc/BRIEF.md
# Pipelined Vector Dot/Cross Product Engine

This block performs three-component vector arithmetic on signed fixed-point components. Each accepted set carries four vectors (A, B, C, D), an operation bit and an operand-select bit. With the operation bit at 0 it forms two dot products side by side, A·B and C·D. With the operation bit at 1 it forms one cross product, either A×B or C×D, chosen by the select bit. One bank of six multipliers serves both operations. A steering stage in front of the bank routes the twelve input components onto six operand pairs according to the two control bits.

The pipeline takes a new set on every clock. There is no back-pressure. The input side has a valid qualifier and a plain enable, and no ready signal, so a set is accepted whenever both are high. Each output side has its own one-cycle valid pulse and no ready signal, so the consumer must capture a result in the cycle its pulse is high. The operation bit travels down the pipeline with its data. Dot results take one stage more than cross results, so a dot set and the cross set issued right after it complete in the same cycle on their separate outputs.

A build parameter places a register on the inputs, clocked when the enable is high, or removes it. The latencies below assume the register is present, which is the default.

Top module: `vecprod_unit`

## Requirements
- R1: Each vector port is 54 bits wide and holds three signed two's-complement 18-bit components: X in bits 17:0, Y in bits 35:18 and Z in bits 53:36.
- R2: A set with opcode 0 yields dot0 = Ax·Bx + Ay·By + Az·Bz and dot1 = Cx·Dx + Cy·Dy + Cz·Dz.
- R3: A set with opcode 1 and sel 0 yields cross_x = Ay·Bz − Az·By, cross_y = Az·Bx − Ax·Bz and cross_z = Ax·By − Ay·Bx.
- R4: A set with opcode 1 and sel 1 yields the same formulas applied to C and D in place of A and B.
- R5: A set sampled at clock edge k is loaded at that edge. cross_valid pulses for it after edge k+3 and dot_valid pulses for it after edge k+4.
- R6: Sets may arrive on consecutive clocks with any mix of operations. Every accepted set yields exactly one result, and results on each output appear in issue order.
- R7: A set is accepted only when in_valid and ena are both high at the sampling edge. Any other set produces no valid pulse.
- R8: Each result group changes only in the cycle its valid pulse is high, and holds its value otherwise.
- R9: Reset clears both valid outputs and every result output to zero. Sets presented during reset produce no result.
- R10: Results are the low 32 bits of the exact signed result, so an overflow wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| in_valid | input | 1 | Marks the presented set as real |
| ena | input | 1 | Input enable; gates loading of the set |
| opcode | input | 1 | 0 selects the dot pair, 1 selects the cross product |
| sel | input | 1 | Cross operand choice: 0 takes A,B and 1 takes C,D |
| vec_a | input | 54 | Vector A |
| vec_b | input | 54 | Vector B |
| vec_c | input | 54 | Vector C |
| vec_d | input | 54 | Vector D |
| dot_valid | output | 1 | One-cycle pulse: dot0/dot1 carry a new result |
| dot0 | output | 32 | A·B |
| dot1 | output | 32 | C·D |
| cross_valid | output | 1 | One-cycle pulse: cross outputs carry a new result |
| cross_x | output | 32 | X component of the cross product |
| cross_y | output | 32 | Y component of the cross product |
| cross_z | output | 32 | Z component of the cross product |

## Verification
The hardest situation to reach is two things at once: both output groups pulsing in the same cycle, and a rejected set (ena or in_valid low) sitting between accepted sets of the other kind. Only in that situation does a mix-up in how the operation bit travels with its data show up. The stimulus alternates dot and cross sets on back-to-back clocks, then runs a long stream where operation, select, in_valid and ena are all random. Per-output queues match each pulse to its issuing set and check the exact cycle distance. Operands pinned at the component extremes drive the wrap-around case.

// File: rtl/vp_pkg.sv
package vp_pkg;
  typedef enum logic {OP_DOT = 1'b0, OP_CROSS = 1'b1} vp_op_e;
  localparam int NMUL = 6;
  localparam int AXES = 3;
  localparam int AX_X = 0;
  localparam int AX_Y = 1;
  localparam int AX_Z = 2;
endpackage

// File: rtl/vp_steer.sv
module vp_steer
  import vp_pkg::*;
#(
  parameter int CW = 18,
  localparam int VW = AXES * CW
) (
  input  logic [VW-1:0]        a,
  input  logic [VW-1:0]        b,
  input  logic [VW-1:0]        c,
  input  logic [VW-1:0]        d,
  input  vp_op_e               op,
  input  logic                 sel,
  output logic signed [CW-1:0] lhs [NMUL],
  output logic signed [CW-1:0] rhs [NMUL]
);
  logic [VW-1:0] u, v;

  function automatic logic signed [CW-1:0] comp(input logic [VW-1:0] w, input int ax);
    return w[ax*CW +: CW];
  endfunction

  assign u = sel ? c : a;
  assign v = sel ? d : b;

  always_comb begin
    if (op == OP_DOT) begin
      for (int i = 0; i < AXES; i++) begin
        lhs[i]        = comp(a, i);
        rhs[i]        = comp(b, i);
        lhs[i + AXES] = comp(c, i);
        rhs[i + AXES] = comp(d, i);
      end
    end else begin
      lhs[0] = comp(u, AX_Y); rhs[0] = comp(v, AX_Z);
      lhs[1] = comp(u, AX_Z); rhs[1] = comp(v, AX_Y);
      lhs[2] = comp(u, AX_Z); rhs[2] = comp(v, AX_X);
      lhs[3] = comp(u, AX_X); rhs[3] = comp(v, AX_Z);
      lhs[4] = comp(u, AX_X); rhs[4] = comp(v, AX_Y);
      lhs[5] = comp(u, AX_Y); rhs[5] = comp(v, AX_X);
    end
  end
endmodule

// File: rtl/vp_mul_bank.sv
module vp_mul_bank
  import vp_pkg::*;
#(
  parameter int CW = 18,
  parameter int RW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_v,
  input  vp_op_e               in_op,
  input  logic signed [CW-1:0] lhs [NMUL],
  input  logic signed [CW-1:0] rhs [NMUL],
  output logic                 out_v,
  output vp_op_e               out_op,
  output logic signed [RW-1:0] prod [NMUL]
);
  logic signed [RW-1:0] le [NMUL];
  logic signed [RW-1:0] re [NMUL];

  // Sign-extend to result width; the low RW bits of the product are exact.
  for (genvar g = 0; g < NMUL; g++) begin : g_ext
    assign le[g] = lhs[g];
    assign re[g] = rhs[g];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      out_v  <= 1'b0;
      out_op <= OP_DOT;
      for (int i = 0; i < NMUL; i++) prod[i] <= '0;
    end else begin
      out_v  <= in_v;
      out_op <= in_op;
      for (int i = 0; i < NMUL; i++) prod[i] <= le[i] * re[i];
    end
  end
endmodule

// File: rtl/vp_combine.sv
module vp_combine
  import vp_pkg::*;
#(
  parameter int RW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_v,
  input  vp_op_e               in_op,
  input  logic signed [RW-1:0] prod [NMUL],
  output logic                 dot_valid,
  output logic [RW-1:0]        dot0,
  output logic [RW-1:0]        dot1,
  output logic                 cross_valid,
  output logic [RW-1:0]        cross_x,
  output logic [RW-1:0]        cross_y,
  output logic [RW-1:0]        cross_z
);
  logic                 s_v;
  vp_op_e               s_op;
  logic signed [RW-1:0] s [4];
  logic                 t_v;
  logic [RW-1:0]        t0, t1;

  // Stage A: cross differences, or dot partial sums with third product carried.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      s_v  <= 1'b0;
      s_op <= OP_DOT;
      for (int i = 0; i < 4; i++) s[i] <= '0;
    end else begin
      s_v  <= in_v;
      s_op <= in_op;
      if (in_op == OP_CROSS) begin
        s[0] <= prod[0] - prod[1];
        s[1] <= prod[2] - prod[3];
        s[2] <= prod[4] - prod[5];
        s[3] <= '0;
      end else begin
        s[0] <= prod[0] + prod[1];
        s[1] <= prod[2];
        s[2] <= prod[3] + prod[4];
        s[3] <= prod[5];
      end
    end
  end

  // Stage B: cross result out; dot final add.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cross_valid <= 1'b0;
      cross_x     <= '0;
      cross_y     <= '0;
      cross_z     <= '0;
      t_v         <= 1'b0;
      t0          <= '0;
      t1          <= '0;
    end else begin
      cross_valid <= s_v && (s_op == OP_CROSS);
      t_v         <= s_v && (s_op == OP_DOT);
      if (s_v && s_op == OP_CROSS) begin
        cross_x <= s[0];
        cross_y <= s[1];
        cross_z <= s[2];
      end
      if (s_v && s_op == OP_DOT) begin
        t0 <= s[0] + s[1];
        t1 <= s[2] + s[3];
      end
    end
  end

  // Stage C: dot result out.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      dot_valid <= 1'b0;
      dot0      <= '0;
      dot1      <= '0;
    end else begin
      dot_valid <= t_v;
      if (t_v) begin
        dot0 <= t0;
        dot1 <= t1;
      end
    end
  end
endmodule

// File: rtl/vecprod_unit.sv
module vecprod_unit
  import vp_pkg::*;
#(
  parameter int CW     = 18,
  parameter int RW     = 32,
  parameter bit IN_REG = 1'b1,
  localparam int VW    = AXES * CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          ena,
  input  logic          opcode,
  input  logic          sel,
  input  logic [VW-1:0] vec_a,
  input  logic [VW-1:0] vec_b,
  input  logic [VW-1:0] vec_c,
  input  logic [VW-1:0] vec_d,
  output logic          dot_valid,
  output logic [RW-1:0] dot0,
  output logic [RW-1:0] dot1,
  output logic          cross_valid,
  output logic [RW-1:0] cross_x,
  output logic [RW-1:0] cross_y,
  output logic [RW-1:0] cross_z
);
  logic [VW-1:0]        ra, rb, rc, rd;
  logic                 r_op, r_sel, r_v;
  logic signed [CW-1:0] lhs [NMUL];
  logic signed [CW-1:0] rhs [NMUL];
  logic                 m_v;
  vp_op_e               m_op;
  logic signed [RW-1:0] prod [NMUL];

  if (IN_REG) begin : g_inreg
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        ra <= '0; rb <= '0; rc <= '0; rd <= '0;
        r_op <= 1'b0; r_sel <= 1'b0; r_v <= 1'b0;
      end else begin
        r_v <= in_valid & ena;
        if (ena) begin
          ra <= vec_a; rb <= vec_b; rc <= vec_c; rd <= vec_d;
          r_op <= opcode; r_sel <= sel;
        end
      end
    end
  end else begin : g_pass
    assign ra = vec_a;
    assign rb = vec_b;
    assign rc = vec_c;
    assign rd = vec_d;
    assign r_op = opcode;
    assign r_sel = sel;
    assign r_v = in_valid & ena;
  end

  vp_steer #(.CW(CW)) u_steer (
    .a(ra), .b(rb), .c(rc), .d(rd),
    .op(vp_op_e'(r_op)), .sel(r_sel),
    .lhs(lhs), .rhs(rhs)
  );

  vp_mul_bank #(.CW(CW), .RW(RW)) u_mul (
    .clk(clk), .rst(rst),
    .in_v(r_v), .in_op(vp_op_e'(r_op)),
    .lhs(lhs), .rhs(rhs),
    .out_v(m_v), .out_op(m_op), .prod(prod)
  );

  vp_combine #(.RW(RW)) u_comb (
    .clk(clk), .rst(rst),
    .in_v(m_v), .in_op(m_op), .prod(prod),
    .dot_valid(dot_valid), .dot0(dot0), .dot1(dot1),
    .cross_valid(cross_valid), .cross_x(cross_x), .cross_y(cross_y), .cross_z(cross_z)
  );
endmodule

// File: rtl/vecprod_chk.sv
module vecprod_chk #(
  parameter int CW     = 18,
  parameter int RW     = 32,
  parameter bit IN_REG = 1'b1,
  localparam int VW    = 3 * CW,
  localparam int LC    = 3 + int'(IN_REG),
  localparam int LD    = 4 + int'(IN_REG)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          ena,
  input logic          opcode,
  input logic          sel,
  input logic [VW-1:0] vec_a,
  input logic [VW-1:0] vec_b,
  input logic [VW-1:0] vec_c,
  input logic [VW-1:0] vec_d,
  input logic          dot_valid,
  input logic [RW-1:0] dot0,
  input logic [RW-1:0] dot1,
  input logic          cross_valid,
  input logic [RW-1:0] cross_x,
  input logic [RW-1:0] cross_y,
  input logic [RW-1:0] cross_z
);
  logic [3:0] since;
  logic       warm;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) since <= '0;
    else if (since != 4'hF) since <= since + 4'd1;
  end
  assign warm = (since >= 4'(LD));

  function automatic logic signed [63:0] cmp(input logic [VW-1:0] w, input int ax);
    logic signed [CW-1:0] t;
    t = w[ax*CW +: CW];
    return 64'(t);
  endfunction

  function automatic logic [RW-1:0] dotf(input logic [VW-1:0] x, input logic [VW-1:0] y);
    logic signed [63:0] acc;
    acc = cmp(x, 0) * cmp(y, 0) + cmp(x, 1) * cmp(y, 1) + cmp(x, 2) * cmp(y, 2);
    return acc[RW-1:0];
  endfunction

  function automatic logic [RW-1:0] crx(input logic [VW-1:0] x, input logic [VW-1:0] y);
    logic signed [63:0] acc;
    acc = cmp(x, 1) * cmp(y, 2) - cmp(x, 2) * cmp(y, 1);
    return acc[RW-1:0];
  endfunction

  assert_cross_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    warm |-> (cross_valid == $past(in_valid & ena & opcode, LC)));

  assert_dot_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    warm |-> (dot_valid == $past(in_valid & ena & ~opcode, LD)));

  assert_dot_value_R2: assert property (@(posedge clk) disable iff (rst)
    (warm && dot_valid) |->
      (dot0 == dotf($past(vec_a, LD), $past(vec_b, LD)) &&
       dot1 == dotf($past(vec_c, LD), $past(vec_d, LD))));

  // R3 and R4: operand choice follows the select bit of the issuing set.
  assert_cross_select_R4: assert property (@(posedge clk) disable iff (rst)
    (warm && cross_valid) |->
      (cross_x == ($past(sel, LC) ? crx($past(vec_c, LC), $past(vec_d, LC))
                                  : crx($past(vec_a, LC), $past(vec_b, LC)))));

  assert_cross_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !cross_valid |-> $stable({cross_x, cross_y, cross_z}));

  assert_dot_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !dot_valid |-> $stable({dot0, dot1}));
endmodule

bind vecprod_unit vecprod_chk #(.CW(CW), .RW(RW), .IN_REG(IN_REG)) u_chk (.*);

// File: tb/sim_vecprod_unit.sv
`timescale 1ns/1ps
module sim_vecprod_unit;
  localparam int CW = 18;
  localparam int RW = 32;
  localparam int VW = 54;
  localparam int LAT_X = 4;  // negedge-to-negedge distance: load edge + 3
  localparam int LAT_D = 5;  // load edge + 4

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, ena = 1'b0, opcode = 1'b0, sel = 1'b0;
  logic [VW-1:0] vec_a = '0, vec_b = '0, vec_c = '0, vec_d = '0;
  logic dot_valid, cross_valid;
  logic [RW-1:0] dot0, dot1, cross_x, cross_y, cross_z;

  always #2.5 clk = ~clk;

  vecprod_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ena(ena), .opcode(opcode), .sel(sel),
    .vec_a(vec_a), .vec_b(vec_b), .vec_c(vec_c), .vec_d(vec_d),
    .dot_valid(dot_valid), .dot0(dot0), .dot1(dot1),
    .cross_valid(cross_valid), .cross_x(cross_x), .cross_y(cross_y), .cross_z(cross_z)
  );

  typedef struct {
    logic [RW-1:0] r0, r1, r2;
    int            issue;
    string         req;
  } exp_t;

  exp_t qx[$];
  exp_t qd[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [RW-1:0] px0 = '0, px1 = '0, px2 = '0, pd0 = '0, pd1 = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [RW-1:0] act, input logic [RW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // R1: X bits 17:0, Y 35:18, Z 53:36, signed.
  function automatic longint cmp(input logic [VW-1:0] w, input int ax);
    logic signed [CW-1:0] t;
    t = w[ax*CW +: CW];
    return longint'(t);
  endfunction

  function automatic logic [VW-1:0] pack(input int x, input int y, input int z);
    logic [31:0] xx, yy, zz;
    xx = x; yy = y; zz = z;
    return {zz[CW-1:0], yy[CW-1:0], xx[CW-1:0]};
  endfunction

  function automatic logic [RW-1:0] dotv(input logic [VW-1:0] p, input logic [VW-1:0] q);
    longint s;
    s = cmp(p, 0) * cmp(q, 0) + cmp(p, 1) * cmp(q, 1) + cmp(p, 2) * cmp(q, 2);
    return s[RW-1:0];
  endfunction

  function automatic logic [RW-1:0] crs(input logic [VW-1:0] p, input logic [VW-1:0] q,
                                        input int i, input int j);
    longint s;
    s = cmp(p, i) * cmp(q, j) - cmp(p, j) * cmp(q, i);
    return s[RW-1:0];
  endfunction

  // Driver: present one set for one cycle, record what must come out.
  task automatic send(input logic op, input logic sl, input logic [VW-1:0] a,
                      input logic [VW-1:0] b, input logic [VW-1:0] c,
                      input logic [VW-1:0] d, input logic iv, input logic en,
                      input string req);
    exp_t e;
    opcode = op; sel = sl; vec_a = a; vec_b = b; vec_c = c; vec_d = d;
    in_valid = iv; ena = en;
    e.issue = cyc;
    e.req = req;
    if (iv && en) begin
      if (!op) begin
        e.r0 = dotv(a, b); e.r1 = dotv(c, d); e.r2 = '0;
        qd.push_back(e);
      end else begin
        e.r0 = sl ? crs(c, d, 1, 2) : crs(a, b, 1, 2);
        e.r1 = sl ? crs(c, d, 2, 0) : crs(a, b, 2, 0);
        e.r2 = sl ? crs(c, d, 0, 1) : crs(a, b, 0, 1);
        qx.push_back(e);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (cross_valid) begin
        if (qx.size() == 0) chk(1'b0, "R7", "unexpected cross pulse", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = qx.pop_front();
          chk(cross_x == e.r0, e.req, "cross_x", cross_x, e.r0);
          chk(cross_y == e.r1, e.req, "cross_y", cross_y, e.r1);
          chk(cross_z == e.r2, e.req, "cross_z", cross_z, e.r2);
          chk(cyc - e.issue == LAT_X, "R5", "cross latency", RW'(cyc - e.issue), RW'(LAT_X));
        end
      end else begin
        chk({cross_x, cross_y, cross_z} == {px0, px1, px2}, "R8", "cross hold", cross_x, px0);
      end
      if (dot_valid) begin
        if (qd.size() == 0) chk(1'b0, "R7", "unexpected dot pulse", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = qd.pop_front();
          chk(dot0 == e.r0, e.req, "dot0", dot0, e.r0);
          chk(dot1 == e.r1, e.req, "dot1", dot1, e.r1);
          chk(cyc - e.issue == LAT_D, "R5", "dot latency", RW'(cyc - e.issue), RW'(LAT_D));
        end
      end else begin
        chk({dot0, dot1} == {pd0, pd1}, "R8", "dot hold", dot0, pd0);
      end
      px0 = cross_x; px1 = cross_y; px2 = cross_z; pd0 = dot0; pd1 = dot1;
    end
  end

  function automatic int rc();
    return int'($urandom_range(0, 262143)) - 131072;
  endfunction

  function automatic logic [VW-1:0] rv();
    return pack(rc(), rc(), rc());
  endfunction

  initial begin
    logic [VW-1:0] hi, lo, mx;
    // R9: set offered during reset must vanish; outputs cleared.
    @(negedge clk);
    opcode = 1'b0; in_valid = 1'b1; ena = 1'b1;
    vec_a = pack(1, 2, 3); vec_b = pack(4, 5, 6);
    repeat (3) @(negedge clk);
    chk(!dot_valid && !cross_valid, "R9", "valids in reset", {30'd0, dot_valid, cross_valid}, 32'd0);
    chk(dot0 == 0 && dot1 == 0, "R9", "dot outputs in reset", dot0, 32'd0);
    chk(cross_x == 0 && cross_y == 0 && cross_z == 0, "R9", "cross outputs in reset", cross_x, 32'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    // R2 plain dot products, R1 negative components
    send(0, 0, pack(1, 2, 3), pack(4, 5, 6), pack(-1, 7, -2), pack(3, -3, 9), 1, 1, "R2");
    send(0, 1, pack(-5, 0, 11), pack(2, 8, -4), pack(131071, 1, 1), pack(2, 2, 2), 1, 1, "R1");
    // R3 / R4 cross with distinct operand pairs
    send(1, 0, pack(1, 0, 0), pack(0, 1, 0), pack(3, -7, 2), pack(5, 1, -6), 1, 1, "R3");
    send(1, 1, pack(1, 0, 0), pack(0, 1, 0), pack(3, -7, 2), pack(5, 1, -6), 1, 1, "R4");
    repeat (8) @(negedge clk);

    // R6 alternating back-to-back: dot and cross pulses coincide
    for (int i = 0; i < 12; i++)
      send(logic'(i % 2), logic'((i / 2) % 2), rv(), rv(), rv(), rv(), 1, 1, "R6");
    // R7 rejected sets interleaved
    send(0, 0, rv(), rv(), rv(), rv(), 1, 0, "R7");
    send(1, 0, rv(), rv(), rv(), rv(), 0, 1, "R7");
    send(1, 1, rv(), rv(), rv(), rv(), 1, 1, "R7");
    send(1, 0, rv(), rv(), rv(), rv(), 1, 0, "R7");
    send(0, 0, rv(), rv(), rv(), rv(), 1, 1, "R7");
    repeat (8) @(negedge clk);

    // R10 wrap at component extremes
    hi = pack(131071, 131071, 131071);
    lo = pack(-131072, -131072, -131072);
    mx = pack(131071, -131072, 131071);
    send(0, 0, hi, hi, lo, lo, 1, 1, "R10");
    send(1, 0, mx, pack(-131072, 131071, -131072), hi, lo, 1, 1, "R10");
    send(1, 1, hi, lo, lo, mx, 1, 1, "R10");
    repeat (8) @(negedge clk);

    // Random stream
    for (int i = 0; i < 400; i++)
      send(logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)), rv(), rv(), rv(), rv(),
           logic'($urandom_range(0, 3) != 0), logic'($urandom_range(0, 4) != 0), "R6");
    repeat (10) @(negedge clk);

    chk(qx.size() == 0, "R6", "cross results missing", RW'(qx.size()), 32'd0);
    chk(qd.size() == 0, "R6", "dot results missing", RW'(qd.size()), 32'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule